// File: doc/BRIEF.md
# Rank-Based Instruction Issue Queue

This block is a small out-of-order issue queue. An upstream dispatch stage first reads a status code that says whether an instruction can be accepted now, and then hands over one instruction per cycle. Each entry holds the instruction's tag, its program-order sequence number, the number of known consumers of its result, two source operands with readiness flags, an optional memory-ordering wait, and an urgency flag. Operand wakeups arrive as a broadcast physical-register tag, and memory-ordering clears arrive by instruction tag. Each cycle the queue promotes waiting entries whose operands and memory ordering are now all satisfied.

A select stage picks one eligible entry per cycle. Urgent entries (zero-latency or must-go-now instructions) come first. After that, the lowest rank wins, where rank is sequence number minus consumer count, so an instruction with many dependants goes ahead of an older one with few. When two ranks are equal, the smaller sequence number wins. The pick is only issued when the execution resource reports free in that cycle. An issued entry stays resident while it executes, and it is released by a writeback carrying its tag.

Sequence numbers are assumed not to wrap while entries are resident. Instruction tags and pending wakeup tags are assumed to be unique.

Top module: `rank_issue_queue`

## Requirements
- R1: After a synchronous active-low reset, the queue holds no entries: `full` is 0, `iss_valid` is 0 and `avail_code` is 0.
- R2: `avail_code` is 1 (queue full) when every slot is occupied. Otherwise it is 2 (load/store queue full) when `disp_is_mem` and `lsq_full` are both high. Otherwise it is 0 (available). A dispatch is taken only while the code is 0; a dispatch offered with any other code leaves no entry behind.
- R3: An entry dispatched with both sources ready and no memory wait is eligible for issue in the next cycle. A wakeup broadcast in the same cycle as the dispatch counts as ready for a matching source.
- R4: A waiting entry becomes eligible once every source tag has been woken and its memory wait has been cleared by tag. If the last of these events arrives in cycle N, the entry issues in cycle N+1 at the earliest and never in cycle N.
- R5: Among eligible entries without the urgent flag, the one with the lowest signed rank (sequence minus consumer count, 10 bits) is issued, including negative ranks.
- R6: When two eligible entries have equal rank, the one with the smaller sequence number is issued first.
- R7: An eligible entry with the urgent flag is issued ahead of every eligible non-urgent entry, whatever the ranks.
- R8: While `res_free` is 0, nothing issues, and eligible entries stay eligible for a later cycle.
- R9: An issued entry is never selected again. It keeps its slot until a writeback with its tag arrives, and the slot is free in the cycle after that writeback.
- R10: `full` is 1 exactly when all DEPTH slots are occupied. A dispatch offered while full is ignored, so that instruction never issues.
- R11: No entry issues while any of its source operands has not been woken or its memory wait is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch offer this cycle |
| disp_tag | input | TAG_W | Instruction tag, used for writeback and memory clears |
| disp_seq | input | SEQ_W | Program-order sequence number |
| disp_users | input | USE_W | Number of known consumers of the result |
| disp_src_tag | input | NSRC*PTAG_W | Physical tags of the sources, source 0 in the low bits |
| disp_src_rdy | input | NSRC | Source already available at dispatch |
| disp_mem_dep | input | 1 | Entry must wait for a memory-ordering clear |
| disp_is_mem | input | 1 | Instruction needs a load/store queue slot |
| disp_urgent | input | 1 | Zero-latency or must-issue-at-once instruction |
| lsq_full | input | 1 | Load/store queue has no room |
| avail_code | output | 2 | 0 available, 1 queue full, 2 load/store queue full |
| full | output | 1 | All slots occupied |
| wk_valid | input | 1 | Operand wakeup broadcast valid |
| wk_ptag | input | PTAG_W | Physical tag that became available |
| mclr_valid | input | 1 | Memory-ordering clear valid |
| mclr_tag | input | TAG_W | Instruction tag whose memory wait is met |
| res_free | input | 1 | Execution resource can accept an issue this cycle |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_tag | output | TAG_W | Tag of the issued instruction |
| wb_valid | input | 1 | Writeback event valid |
| wb_tag | input | TAG_W | Tag of the instruction finishing execution |

## Verification
The bench goes after the ranking corners: a negative rank that must beat every positive one, two equal ranks where only the sequence number decides, and an urgent entry with a poor rank. A comparator that ignored the sign, dropped the tie-break or skipped the urgency bit would issue in the wrong order. It drives a wakeup in the very cycle the bench also expects no issue, so a design that let the promoted entry bypass into the same cycle's pick would issue one cycle early. It also wakes one of two sources and expects nothing, which catches an entry that became eligible on a partial wakeup. It fills all eight slots and offers an older instruction while full. A queue that still accepted it would issue it first, and a queue that freed slots at issue instead of at writeback would drop `full` too early.

// File: rtl/iq_pkg.sv
// Package iq_pkg
// Shared types for the rank-based issue queue: the life cycle of one slot and
// the status code returned to the dispatch stage before it offers work.
package iq_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2,
        SLOT_EXEC  = 2'd3
    } slot_state_e;

    typedef enum logic [1:0] {
        DSP_OK      = 2'd0,
        DSP_QFULL   = 2'd1,
        DSP_LSQFULL = 2'd2
    } disp_status_e;

endpackage

// File: rtl/iq_entry.sv
// Module iq_entry
// One issue-queue slot. It captures an instruction on alloc_en, tracks source
// wakeups and a memory-ordering wait, becomes eligible once everything is
// satisfied, moves to executing on grant and frees itself on a writeback that
// carries its tag.
// Assumes: alloc_en only while free, grant only while eligible, and unique tags.
module iq_entry #(
    parameter int TAG_W  = 4,
    parameter int SEQ_W  = 8,
    parameter int USE_W  = 4,
    parameter int PTAG_W = 5,
    parameter int NSRC   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_en,
    input  logic [TAG_W-1:0]       a_tag,
    input  logic [SEQ_W-1:0]       a_seq,
    input  logic [USE_W-1:0]       a_users,
    input  logic [NSRC*PTAG_W-1:0] a_src_tag,
    input  logic [NSRC-1:0]        a_src_rdy,
    input  logic                   a_mem_wait,
    input  logic                   a_urgent,
    input  logic                   wk_valid,
    input  logic [PTAG_W-1:0]      wk_ptag,
    input  logic                   mclr_valid,
    input  logic [TAG_W-1:0]       mclr_tag,
    input  logic                   grant,
    input  logic                   wb_valid,
    input  logic [TAG_W-1:0]       wb_tag,
    output logic                   occupied,
    output logic                   eligible,
    output logic [TAG_W-1:0]       e_tag,
    output logic [SEQ_W-1:0]       e_seq,
    output logic [USE_W-1:0]       e_users,
    output logic                   e_urgent
);
    import iq_pkg::*;

    slot_state_e               state;
    logic [TAG_W-1:0]          tag_q;
    logic [SEQ_W-1:0]          seq_q;
    logic [USE_W-1:0]          users_q;
    logic                      urg_q;
    logic [NSRC*PTAG_W-1:0]    src_tag_q;
    logic [NSRC-1:0]           src_rdy_q;
    logic                      mem_pend_q;

    logic [NSRC-1:0]           held_hit;
    logic [NSRC-1:0]           new_hit;
    logic [NSRC-1:0]           rdy_upd;
    logic [NSRC-1:0]           rdy_new;
    logic                      mem_upd;
    logic                      mem_new;

    // Match the wakeup broadcast against held and incoming source tags.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            held_hit[s] = wk_valid && (src_tag_q[s*PTAG_W +: PTAG_W] == wk_ptag);
            new_hit[s]  = wk_valid && (a_src_tag[s*PTAG_W +: PTAG_W] == wk_ptag);
        end
        rdy_upd = src_rdy_q | held_hit;
        rdy_new = a_src_rdy | new_hit;
        mem_upd = mem_pend_q & ~(mclr_valid && (mclr_tag == tag_q));
        mem_new = a_mem_wait & ~(mclr_valid && (mclr_tag == a_tag));
    end

    // Slot life cycle: free -> waiting/ready -> executing -> free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SLOT_FREE;
            tag_q      <= '0;
            seq_q      <= '0;
            users_q    <= '0;
            urg_q      <= 1'b0;
            src_tag_q  <= '0;
            src_rdy_q  <= '0;
            mem_pend_q <= 1'b0;
        end else begin
            case (state)
                SLOT_FREE: begin
                    if (alloc_en) begin
                        tag_q      <= a_tag;
                        seq_q      <= a_seq;
                        users_q    <= a_users;
                        urg_q      <= a_urgent;
                        src_tag_q  <= a_src_tag;
                        src_rdy_q  <= rdy_new;
                        mem_pend_q <= mem_new;
                        state      <= (&rdy_new && !mem_new) ? SLOT_READY : SLOT_WAIT;
                    end
                end
                SLOT_WAIT: begin
                    src_rdy_q  <= rdy_upd;
                    mem_pend_q <= mem_upd;
                    if (&rdy_upd && !mem_upd) state <= SLOT_READY;
                end
                SLOT_READY: begin
                    if (grant) state <= SLOT_EXEC;
                end
                SLOT_EXEC: begin
                    if (wb_valid && (wb_tag == tag_q)) state <= SLOT_FREE;
                end
                default: state <= SLOT_FREE;
            endcase
        end
    end

    assign occupied = (state != SLOT_FREE);
    assign eligible = (state == SLOT_READY);
    assign e_tag    = tag_q;
    assign e_seq    = seq_q;
    assign e_users  = users_q;
    assign e_urgent = urg_q;

    // R11: a grant only reaches a slot that is in the eligible state.
    p_grant_needs_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (state == SLOT_READY));
    // R4: an eligible slot has every source woken and no memory wait left.
    p_ready_all_met_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_READY) |-> (&src_rdy_q && !mem_pend_q));
    // R9: a granted slot is executing on the next cycle.
    p_issue_to_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (state == SLOT_EXEC));
    // R10: allocation never overwrites a resident slot.
    p_alloc_into_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (state == SLOT_FREE));

endmodule

// File: rtl/iq_alloc.sv
// Module iq_alloc
// Availability check and slot allocator. It produces the stall code for the
// dispatch stage and, when a dispatch is taken, a one-hot pick of the
// lowest-numbered free slot.
// Assumes: occ reflects slot occupancy at the start of the cycle.
module iq_alloc #(
    parameter int DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEPTH-1:0]        occ,
    input  logic                    disp_valid,
    input  logic                    disp_is_mem,
    input  logic                    lsq_full,
    output iq_pkg::disp_status_e    status,
    output logic                    full,
    output logic [DEPTH-1:0]        alloc_oh
);
    import iq_pkg::*;

    logic [DEPTH-1:0] first_free;
    logic             found;

    // Stall code: a full queue takes precedence over a full load/store queue.
    always_comb begin
        full = &occ;
        if (full)                          status = DSP_QFULL;
        else if (disp_is_mem && lsq_full)  status = DSP_LSQFULL;
        else                               status = DSP_OK;
    end

    // Lowest free slot, committed only when the dispatch is accepted.
    always_comb begin
        first_free = '0;
        found      = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!occ[i] && !found) begin
                first_free[i] = 1'b1;
                found         = 1'b1;
            end
        end
        alloc_oh = (disp_valid && (status == DSP_OK)) ? first_free : '0;
    end

    // R10: at most one slot is filled per cycle.
    p_single_alloc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_oh));
    // R2: a memory instruction never allocates while the load/store queue is full.
    p_lsq_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_is_mem && lsq_full) |-> (alloc_oh == '0));

endmodule

// File: rtl/iq_select.sv
// Module iq_select
// Pick-one selector built as a balanced comparison tree over per-slot keys.
// The smaller key wins, and on equal keys the lower slot index wins. The
// winner is granted only when the execution resource is free.
// Assumes: keys are unsigned-comparable (the caller biases any signed fields).
module iq_select #(
    parameter int DEPTH = 8,
    parameter int KEY_W = 19
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DEPTH-1:0]       req,
    input  logic [DEPTH*KEY_W-1:0] keys,
    input  logic                   res_free,
    output logic                   iss_ok,
    output logic [DEPTH-1:0]       grant
);
    localparam int LVL   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int N2    = 1 << LVL;
    localparam int NODES = 2 * N2 - 1;
    localparam int IDX_W = LVL;

    logic             nv [NODES];
    logic [KEY_W-1:0] nk [NODES];
    logic [IDX_W-1:0] ni [NODES];

    // Leaves: one per slot, padded with empty leaves up to a power of two.
    for (genvar i = 0; i < N2; i++) begin : g_leaf
        if (i < DEPTH) begin : g_real
            assign nv[N2-1+i] = req[i];
            assign nk[N2-1+i] = keys[i*KEY_W +: KEY_W];
            assign ni[N2-1+i] = IDX_W'(i);
        end else begin : g_pad
            assign nv[N2-1+i] = 1'b0;
            assign nk[N2-1+i] = '0;
            assign ni[N2-1+i] = '0;
        end
    end

    // Internal nodes: keep the smaller key, the left child winning ties.
    for (genvar n = 0; n < N2 - 1; n++) begin : g_node
        logic take_l;
        assign take_l = nv[2*n+1] && (!nv[2*n+2] || (nk[2*n+1] <= nk[2*n+2]));
        assign nv[n]  = nv[2*n+1] || nv[2*n+2];
        assign nk[n]  = take_l ? nk[2*n+1] : nk[2*n+2];
        assign ni[n]  = take_l ? ni[2*n+1] : ni[2*n+2];
    end

    assign iss_ok = nv[0] && res_free;
    assign grant  = iss_ok ? (DEPTH'(1) << ni[0]) : '0;

    // R5: the root key is no larger than the key of any requesting slot.
    always @(posedge clk) begin
        if (rst_n && nv[0]) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (req[i]) begin
                    p_root_is_min_r5: assert (nk[0] <= keys[i*KEY_W +: KEY_W]);
                end
            end
        end
    end

endmodule

// File: rtl/rank_issue_queue.sv
// Module rank_issue_queue
// Top of the issue queue: allocator, DEPTH slots and the rank selector.
// Each slot's key is {not urgent, biased rank, sequence}. The rank is the
// sequence number minus the consumer count, in RANK_W signed bits, and the
// sign bit is inverted so that an unsigned compare orders ranks correctly.
// Assumes: unique tags among resident entries, no sequence wrap while resident.
module rank_issue_queue #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 4,
    parameter int SEQ_W  = 8,
    parameter int USE_W  = 4,
    parameter int PTAG_W = 5,
    parameter int NSRC   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    input  logic [TAG_W-1:0]       disp_tag,
    input  logic [SEQ_W-1:0]       disp_seq,
    input  logic [USE_W-1:0]       disp_users,
    input  logic [NSRC*PTAG_W-1:0] disp_src_tag,
    input  logic [NSRC-1:0]        disp_src_rdy,
    input  logic                   disp_mem_dep,
    input  logic                   disp_is_mem,
    input  logic                   disp_urgent,
    input  logic                   lsq_full,
    output logic [1:0]             avail_code,
    output logic                   full,
    input  logic                   wk_valid,
    input  logic [PTAG_W-1:0]      wk_ptag,
    input  logic                   mclr_valid,
    input  logic [TAG_W-1:0]       mclr_tag,
    input  logic                   res_free,
    output logic                   iss_valid,
    output logic [TAG_W-1:0]       iss_tag,
    input  logic                   wb_valid,
    input  logic [TAG_W-1:0]       wb_tag
);
    import iq_pkg::*;

    localparam int RANK_W = SEQ_W + 2;
    localparam int KEY_W  = 1 + RANK_W + SEQ_W;

    disp_status_e           status;
    logic [DEPTH-1:0]       occ;
    logic [DEPTH-1:0]       elig;
    logic [DEPTH-1:0]       alloc_oh;
    logic [DEPTH-1:0]       grant;
    logic [DEPTH*KEY_W-1:0] keys;
    logic [TAG_W-1:0]       ent_tag   [DEPTH];
    logic [SEQ_W-1:0]       ent_seq   [DEPTH];
    logic [USE_W-1:0]       ent_users [DEPTH];
    logic                   ent_urg   [DEPTH];

    iq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .occ         (occ),
        .disp_valid  (disp_valid),
        .disp_is_mem (disp_is_mem),
        .lsq_full    (lsq_full),
        .status      (status),
        .full        (full),
        .alloc_oh    (alloc_oh)
    );

    assign avail_code = status;

    // One slot and its ranking key per queue position.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [RANK_W-1:0] rank;

        iq_entry #(
            .TAG_W (TAG_W),
            .SEQ_W (SEQ_W),
            .USE_W (USE_W),
            .PTAG_W(PTAG_W),
            .NSRC  (NSRC)
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_oh[g]),
            .a_tag      (disp_tag),
            .a_seq      (disp_seq),
            .a_users    (disp_users),
            .a_src_tag  (disp_src_tag),
            .a_src_rdy  (disp_src_rdy),
            .a_mem_wait (disp_mem_dep),
            .a_urgent   (disp_urgent),
            .wk_valid   (wk_valid),
            .wk_ptag    (wk_ptag),
            .mclr_valid (mclr_valid),
            .mclr_tag   (mclr_tag),
            .grant      (grant[g]),
            .wb_valid   (wb_valid),
            .wb_tag     (wb_tag),
            .occupied   (occ[g]),
            .eligible   (elig[g]),
            .e_tag      (ent_tag[g]),
            .e_seq      (ent_seq[g]),
            .e_users    (ent_users[g]),
            .e_urgent   (ent_urg[g])
        );

        assign rank = {2'b00, ent_seq[g]} - RANK_W'(ent_users[g]);
        assign keys[g*KEY_W +: KEY_W] =
            {~ent_urg[g], ~rank[RANK_W-1], rank[RANK_W-2:0], ent_seq[g]};
    end

    iq_select #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (elig),
        .keys     (keys),
        .res_free (res_free),
        .iss_ok   (iss_valid),
        .grant    (grant)
    );

    // Tag of the granted slot for the execution side.
    always_comb begin
        iss_tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) iss_tag = iss_tag | ent_tag[i];
        end
    end

    // R10: occupancy does not grow past a cycle that starts full.
    p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> ($countones(occ) <= $past($countones(occ))));
    // R8: eligible work survives a cycle without a free resource.
    p_ready_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|elig) && !res_free) |=> (|elig));

endmodule

// File: tb/rank_issue_queue_bench.sv
// Bench for rank_issue_queue: a behavioural model of resident instructions
// compared with the outputs every cycle, plus directed expectations.
module rank_issue_queue_bench;
    localparam int DEPTH = 8, TAG_W = 4, SEQ_W = 8, USE_W = 4, PTAG_W = 5, NSRC = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, disp_valid, disp_mem_dep, disp_is_mem, disp_urgent, lsq_full;
    logic [TAG_W-1:0] disp_tag, mclr_tag, wb_tag, iss_tag;
    logic [SEQ_W-1:0] disp_seq;
    logic [USE_W-1:0] disp_users;
    logic [NSRC*PTAG_W-1:0] disp_src_tag;
    logic [NSRC-1:0] disp_src_rdy;
    logic [1:0] avail_code;
    logic full, wk_valid, mclr_valid, res_free, iss_valid, wb_valid;
    logic [PTAG_W-1:0] wk_ptag;

    rank_issue_queue u_rank_issue_queue (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_seq(disp_seq), .disp_users(disp_users), .disp_src_tag(disp_src_tag),
        .disp_src_rdy(disp_src_rdy), .disp_mem_dep(disp_mem_dep),
        .disp_is_mem(disp_is_mem), .disp_urgent(disp_urgent), .lsq_full(lsq_full),
        .avail_code(avail_code), .full(full), .wk_valid(wk_valid), .wk_ptag(wk_ptag),
        .mclr_valid(mclr_valid), .mclr_tag(mclr_tag), .res_free(res_free),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .wb_valid(wb_valid), .wb_tag(wb_tag)
    );

    // Model: 0 free, 1 waiting, 2 eligible, 3 executing.
    int mst [DEPTH];
    int mtag [DEPTH], mseq [DEPTH], muse [DEPTH], msrc [DEPTH][NSRC];
    bit mrdy [DEPTH][NSRC];
    bit mmem [DEPTH], murg [DEPTH];

    int total = 0, fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit better(int a, int b);
        int ra = mseq[a] - muse[a];
        int rb = mseq[b] - muse[b];
        if (murg[a] != murg[b]) return murg[a];
        if (ra != rb) return ra < rb;
        return mseq[a] < mseq[b];
    endfunction

    function automatic int pick();
        int best = -1;
        for (int i = 0; i < DEPTH; i++)
            if (mst[i] == 2 && (best < 0 || better(i, best))) best = i;
        return best;
    endfunction

    function automatic int count_occ();
        int c = 0;
        for (int i = 0; i < DEPTH; i++) if (mst[i] != 0) c++;
        return c;
    endfunction

    task automatic model_edge(int p, bit issue, int code);
        int slot = -1;
        for (int i = 0; i < DEPTH; i++) if (mst[i] == 0 && slot < 0) slot = i;
        for (int i = 0; i < DEPTH; i++)
            if (wb_valid && mst[i] == 3 && mtag[i] == int'(wb_tag)) mst[i] = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mst[i] == 1) begin
                bit all = 1'b1;
                for (int s = 0; s < NSRC; s++) begin
                    if (wk_valid && msrc[i][s] == int'(wk_ptag)) mrdy[i][s] = 1'b1;
                    all &= mrdy[i][s];
                end
                if (mclr_valid && mtag[i] == int'(mclr_tag)) mmem[i] = 1'b0;
                if (all && !mmem[i]) mst[i] = 2;
            end
        end
        if (issue) mst[p] = 3;
        if (disp_valid && code == 0 && slot >= 0) begin
            bit all = 1'b1;
            mtag[slot] = int'(disp_tag); mseq[slot] = int'(disp_seq);
            muse[slot] = int'(disp_users); murg[slot] = disp_urgent;
            for (int s = 0; s < NSRC; s++) begin
                msrc[slot][s] = int'(disp_src_tag[s*PTAG_W +: PTAG_W]);
                mrdy[slot][s] = disp_src_rdy[s] ||
                                (wk_valid && msrc[slot][s] == int'(wk_ptag));
                all &= mrdy[slot][s];
            end
            mmem[slot] = disp_mem_dep && !(mclr_valid && disp_tag == mclr_tag);
            mst[slot] = (all && !mmem[slot]) ? 2 : 1;
        end
    endtask

    // One clock: compare with the model, advance it, clear pulse inputs.
    task automatic step();
        int p, ec, cnt;
        bit ev;
        #2;
        cnt = count_occ();
        ec = (cnt == DEPTH) ? 1 : ((disp_is_mem && lsq_full) ? 2 : 0);
        p = pick();
        ev = res_free && (p >= 0);
        chk(full == (cnt == DEPTH), "R10", "full", int'(full), int'(cnt == DEPTH));
        chk(int'(avail_code) == ec, "R2", "avail_code", int'(avail_code), ec);
        chk(iss_valid == ev, cur_req, "iss_valid", int'(iss_valid), int'(ev));
        if (ev && iss_valid)
            chk(int'(iss_tag) == mtag[p], cur_req, "iss_tag", int'(iss_tag), mtag[p]);
        model_edge(p, ev, ec);
        @(negedge clk);
        disp_valid = 0; wk_valid = 0; mclr_valid = 0; wb_valid = 0;
        disp_mem_dep = 0; disp_is_mem = 0; disp_urgent = 0;
    endtask

    task automatic offer(int tag, int seq, int users, int p0, bit r0, int p1, bit r1,
                         bit mem, bit urg);
        disp_valid = 1; disp_tag = TAG_W'(tag); disp_seq = SEQ_W'(seq);
        disp_users = USE_W'(users);
        disp_src_tag = {PTAG_W'(p1), PTAG_W'(p0)}; disp_src_rdy = {r1, r0};
        disp_mem_dep = mem; disp_is_mem = mem; disp_urgent = urg;
    endtask

    task automatic expect_iss(string req, bit v, int tag);
        #1;
        chk(iss_valid == v, req, "issue valid", int'(iss_valid), int'(v));
        if (v) chk(int'(iss_tag) == tag, req, "issue tag", int'(iss_tag), tag);
    endtask

    task automatic retire(int tag);
        wb_valid = 1; wb_tag = TAG_W'(tag); step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL all requirements watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mst[i] = 0;
        rst_n = 0; disp_valid = 0; disp_tag = 0; disp_seq = 0; disp_users = 0;
        disp_src_tag = 0; disp_src_rdy = 0; disp_mem_dep = 0; disp_is_mem = 0;
        disp_urgent = 0; lsq_full = 0; wk_valid = 0; wk_ptag = 0; mclr_valid = 0;
        mclr_tag = 0; res_free = 0; wb_valid = 0; wb_tag = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: empty after reset.
        #1;
        chk(full == 0, "R1", "full", int'(full), 0);
        chk(iss_valid == 0, "R1", "iss_valid", int'(iss_valid), 0);
        chk(avail_code == 0, "R1", "avail_code", int'(avail_code), 0);
        step();

        // R2: load/store queue stall rejects a memory dispatch.
        cur_req = "R2"; res_free = 1; lsq_full = 1;
        offer(1, 1, 0, 0, 1, 0, 1, 1, 0);
        #1 chk(avail_code == 2, "R2", "lsq stall code", int'(avail_code), 2);
        step(); lsq_full = 0;
        expect_iss("R2", 0, 0); step();

        // R3: ready at dispatch issues next cycle; same-cycle wakeup bypass.
        cur_req = "R3";
        offer(2, 10, 0, 0, 1, 0, 1, 0, 0);
        expect_iss("R3", 0, 0); step();
        expect_iss("R3", 1, 2); step();
        cur_req = "R9"; wb_valid = 1; wb_tag = 2;
        expect_iss("R9", 0, 0); step();
        cur_req = "R3";
        offer(3, 11, 0, 7, 0, 0, 1, 0, 0); wk_valid = 1; wk_ptag = 7; step();
        expect_iss("R3", 1, 3); step();
        retire(3);

        // R4: register wakeup and memory clear promote after one cycle.
        cur_req = "R4";
        offer(4, 12, 0, 9, 0, 0, 1, 0, 0); step();
        for (int k = 0; k < 3; k++) begin expect_iss("R4", 0, 0); step(); end
        wk_valid = 1; wk_ptag = 9;
        expect_iss("R4", 0, 0); step();
        expect_iss("R4", 1, 4); step();
        retire(4);
        offer(5, 13, 0, 0, 1, 0, 1, 1, 0); step();
        for (int k = 0; k < 2; k++) begin expect_iss("R4", 0, 0); step(); end
        mclr_valid = 1; mclr_tag = 5;
        expect_iss("R4", 0, 0); step();
        expect_iss("R4", 1, 5); step();
        retire(5);

        // R11: partial wakeup keeps the entry waiting.
        cur_req = "R11";
        offer(14, 70, 0, 3, 0, 4, 0, 0, 0); step();
        wk_valid = 1; wk_ptag = 3; step();
        expect_iss("R11", 0, 0); step();
        wk_valid = 1; wk_ptag = 4; step();
        expect_iss("R11", 1, 14); step();
        retire(14);

        // R5 / R8: rank order including a negative rank; hold while busy.
        cur_req = "R5"; res_free = 0;
        offer(6, 20, 0, 0, 1, 0, 1, 0, 0); step();
        offer(7, 25, 8, 0, 1, 0, 1, 0, 0); step();
        offer(8, 30, 15, 0, 1, 0, 1, 0, 0); step();
        offer(1, 5, 12, 0, 1, 0, 1, 0, 0); step();
        cur_req = "R8";
        for (int k = 0; k < 2; k++) begin expect_iss("R8", 0, 0); step(); end
        cur_req = "R5"; res_free = 1;
        expect_iss("R5", 1, 1); step();
        expect_iss("R5", 1, 8); step();
        expect_iss("R5", 1, 7); step();
        expect_iss("R5", 1, 6); step();
        retire(1); retire(8); retire(7); retire(6);

        // R6: equal rank, older first.
        cur_req = "R6"; res_free = 0;
        offer(9, 41, 3, 0, 1, 0, 1, 0, 0); step();
        offer(10, 40, 2, 0, 1, 0, 1, 0, 0); step();
        res_free = 1;
        expect_iss("R6", 1, 10); step();
        expect_iss("R6", 1, 9); step();
        retire(9); retire(10);

        // R7: urgent beats a better rank.
        cur_req = "R7"; res_free = 0;
        offer(12, 51, 15, 0, 1, 0, 1, 0, 0); step();
        offer(11, 50, 0, 0, 1, 0, 1, 0, 1); step();
        res_free = 1;
        expect_iss("R7", 1, 11); step();
        expect_iss("R7", 1, 12); step();
        retire(11); retire(12);

        // R10 / R9: fill, reject while full, free only on writeback.
        cur_req = "R10"; res_free = 0;
        for (int i = 0; i < DEPTH; i++) begin
            offer(i, 60 + i, 0, 0, 1, 0, 1, 0, 0); step();
        end
        #1;
        chk(full == 1, "R10", "full after fill", int'(full), 1);
        chk(avail_code == 1, "R2", "queue full code", int'(avail_code), 1);
        offer(13, 59, 0, 0, 1, 0, 1, 0, 0); step();
        res_free = 1;
        for (int i = 0; i < DEPTH; i++) begin expect_iss("R10", 1, i); step(); end
        expect_iss("R10", 0, 0);
        chk(full == 1, "R9", "full while executing", int'(full), 1);
        step();
        cur_req = "R9";
        retire(0);
        #1 chk(full == 0, "R9", "full after writeback", int'(full), 0);
        for (int i = 1; i < DEPTH; i++) retire(i);
        step();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule